// File: doc/BRIEF.md
# Tamper Security State Controller

This block keeps track of whether a battery-backed security unit can be trusted. It holds two flags: a non-valid flag, which is set whenever battery power returns, and a security-violation flag, which marks the failure condition. Ten tamper event inputs feed the block. Each one latches its own status bit. Each one also has an enable bit in a tamper configuration register. An enabled event forces the unit into failure, which also halts the time counter downstream.

Leaving failure takes a fixed procedure, and the block enforces it. First, a system reset must arrive while the unit is in failure; this gives the combined non-valid plus failure state. Then software turns off the tamper enables. Next it clears the event bits, then the violation flag, and last the non-valid flag. A control register holds sticky lock bits. Hard locks are cleared only by battery reset. Soft locks are also cleared by system reset.

Software reaches the registers through a single write port. Writes go to one of four registers, selected by a 2-bit code: 0 = control, 1 = status, 2 = tamper configuration, 3 = interrupt enable. All four registers are always visible on output ports.

Top module: `tamper_sec_ctrl`

## Requirements
- R1: While battery reset (`bat_rst_n` low) is active, status reads exactly 0x2 (non-valid at bit 1 set, violation at bit 0 clear). Control, tamper configuration and interrupt enable all read 0, and `sec_irq_o` and `tc_run_o` are low.
- R2: A pulse on event input `evt_in[i]` sets its status bit whatever the enable setting. Event index i maps to status bit 16+i for i<8, bit 2 for i=8 (time overflow) and bit 3 for i=9 (monotonic overflow).
- R3: Writing 1 to an event status bit (select 1) clears it. While the event input is still asserted, the set wins and the bit stays 1.
- R4: Tamper configuration bit i enables event i. When a latched or present event has its enable set, the violation flag (status bit 0) is set on the next cycle.
- R5: `tc_run_o` is high only when control bit 3 (time counter enable) is set and both the violation flag and the non-valid flag are clear.
- R6: A system reset pulse while the violation flag is set also sets the non-valid flag, unless the failure hard lock (control bit 16) is set. While bit 16 is set, the violation flag cannot be cleared.
- R7: Writing 1 to status bit 0 clears the violation flag only when all three hold: the non-valid flag is set, control bit 16 is clear, and no enabled event is latched or present. Otherwise the write is ignored.
- R8: Writing 1 to status bit 1 clears the non-valid flag only when the violation flag is clear. Otherwise the write is ignored.
- R9: A tamper configuration write is dropped while any event status bit is set and either configuration lock bit is set: control bit 30 (hard) or control bit 29 (soft). When neither condition blocks it, the write is accepted.
- R10: Control bits 30, 29 and 16 are set by writing 1 and are never cleared by a write. A system reset clears only bit 29. Bit 3 follows the written value.
- R11: `sec_irq_o` is high when the violation flag and interrupt enable bit 0 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bat_rst_n | input | 1 | Battery power-on reset, asynchronous, active low |
| sys_rst | input | 1 | System reset pulse, synchronous, active high |
| evt_in | input | 10 | Tamper event detect inputs (index order as in R4) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 status, 2 tamper config, 3 interrupt enable |
| wr_data | input | 32 | Write data |
| ctrl_o | output | 32 | Control register (locks, counter enable) |
| status_o | output | 32 | Status register (events, non-valid, violation) |
| tcfg_o | output | 32 | Tamper configuration (enables in bits 9..0) |
| irq_en_o | output | 32 | Interrupt enable register (bit 0) |
| sec_irq_o | output | 1 | Security-violation interrupt |
| tc_run_o | output | 1 | Time counter run permission |

## Verification
The checker enforces several rules on every cycle. An enabled latched event always raises the violation flag. The violation flag cannot drop while the non-valid flag is clear or the failure hard lock is set. The non-valid flag cannot drop while the violation flag is set. A locked configuration stays stable while any event is pending, and hard locks never fall. Other behaviours only show up in the bench's scenarios. These are the mapping of every event to its status bit, set-over-clear on a held event, the full recovery order, the system-reset transition, soft-lock release on system reset, and the interrupt and counter-run outputs.

// File: rtl/tamper_sm_pkg.sv
package tamper_sm_pkg;
   localparam int NUM_EVT = 10;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_STAT = 2'd1,
      SEL_TCFG = 2'd2,
      SEL_IEN  = 2'd3
   } reg_sel_e;

   // control register bit positions
   localparam int CTL_CFG_HL  = 30;
   localparam int CTL_CFG_SL  = 29;
   localparam int CTL_FAIL_HL = 16;
   localparam int CTL_TC_EN   = 3;

   // status register flag positions
   localparam int ST_NV = 1;
   localparam int ST_SV = 0;

   // event index (enable order) to status bit position
   function automatic int evt_stat_pos(input int idx);
      return (idx >= 8) ? (idx - 6) : (idx + 16);
   endfunction
endpackage

// File: rtl/tamper_evt_bank.sv
module tamper_evt_bank
   import tamper_sm_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               bat_rst_n,
   input  logic [NUM_EVT-1:0] evt_raw,
   input  logic [NUM_EVT-1:0] clr_req,
   output logic [NUM_EVT-1:0] evt_now,
   output logic [NUM_EVT-1:0] evt_stat
);
   // optional input synchronizer, chosen by parameter
   if (SYNC_STAGES == 0) begin : g_nosync
      assign evt_now = evt_raw;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0][NUM_EVT-1:0] chain_q;
      always_ff @(posedge clk or negedge bat_rst_n) begin
         if (!bat_rst_n) chain_q <= '0;
         else begin
            chain_q[0] <= evt_raw;
            for (int s = 1; s < SYNC_STAGES; s++) chain_q[s] <= chain_q[s-1];
         end
      end
      assign evt_now = chain_q[SYNC_STAGES-1];
   end

   // one sticky status bit per event: set dominates write-one-to-clear
   for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
      always_ff @(posedge clk or negedge bat_rst_n) begin
         if (!bat_rst_n)      evt_stat[i] <= 1'b0;
         else if (evt_now[i]) evt_stat[i] <= 1'b1;
         else if (clr_req[i]) evt_stat[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/tamper_lock_reg.sv
module tamper_lock_reg
   import tamper_sm_pkg::*;
#(
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             bat_rst_n,
   input  logic             sys_rst,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] ctrl_q
);
   localparam logic [REG_W-1:0] HARD_MASK = (REG_W'(1) << CTL_CFG_HL) | (REG_W'(1) << CTL_FAIL_HL);
   localparam logic [REG_W-1:0] SOFT_MASK = REG_W'(1) << CTL_CFG_SL;
   localparam logic [REG_W-1:0] LOCK_MASK = HARD_MASK | SOFT_MASK;
   localparam logic [REG_W-1:0] TCE_MASK  = REG_W'(1) << CTL_TC_EN;

   always_ff @(posedge clk or negedge bat_rst_n) begin
      if (!bat_rst_n)   ctrl_q <= '0;
      else if (sys_rst) ctrl_q <= ctrl_q & ~SOFT_MASK;
      else if (wr)      ctrl_q <= ((ctrl_q | wdata) & LOCK_MASK) | (wdata & TCE_MASK);
   end
endmodule

// File: rtl/tamper_sec_flags.sv
module tamper_sec_flags (
   input  logic clk,
   input  logic bat_rst_n,
   input  logic sys_rst,
   input  logic stat_wr,
   input  logic sv_w1c,
   input  logic nv_w1c,
   input  logic sv_set,
   input  logic fail_hl,
   output logic svf_q,
   output logic nvf_q
);
   logic sv_clr_ok, nv_clr_ok, nv_enter;

   assign sv_clr_ok = stat_wr && sv_w1c && nvf_q && !fail_hl;
   assign nv_clr_ok = stat_wr && nv_w1c && !svf_q && !sv_set;
   assign nv_enter  = sys_rst && svf_q && !fail_hl;

   always_ff @(posedge clk or negedge bat_rst_n) begin
      if (!bat_rst_n)     svf_q <= 1'b0;
      else if (sv_set)    svf_q <= 1'b1;
      else if (sv_clr_ok) svf_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge bat_rst_n) begin
      if (!bat_rst_n)     nvf_q <= 1'b1;
      else if (nv_enter)  nvf_q <= 1'b1;
      else if (nv_clr_ok) nvf_q <= 1'b0;
   end
endmodule

// File: rtl/tamper_sec_ctrl.sv
module tamper_sec_ctrl
   import tamper_sm_pkg::*;
#(
   parameter int REG_W    = 32,
   parameter int EVT_SYNC = 2
) (
   input  logic               clk,
   input  logic               bat_rst_n,
   input  logic               sys_rst,
   input  logic [NUM_EVT-1:0] evt_in,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [REG_W-1:0]   wr_data,
   output logic [REG_W-1:0]   ctrl_o,
   output logic [REG_W-1:0]   status_o,
   output logic [REG_W-1:0]   tcfg_o,
   output logic [REG_W-1:0]   irq_en_o,
   output logic               sec_irq_o,
   output logic               tc_run_o
);
   if (REG_W < 32) begin : g_bad_width
      $error("tamper_sec_ctrl: REG_W must be at least 32");
   end
   if (EVT_SYNC < 0 || EVT_SYNC > 4) begin : g_bad_sync
      $error("tamper_sec_ctrl: EVT_SYNC must be 0..4");
   end

   reg_sel_e           sel;
   logic               wr_ok, ctrl_wr, stat_wr, tcfg_wr, ien_wr;
   logic [NUM_EVT-1:0] evt_now, evt_stat, evt_clr, tcfg_q;
   logic [REG_W-1:0]   ctrl_q;
   logic               ien_q, svf_q, nvf_q, evt_hit, cfg_locked;

   assign sel     = reg_sel_e'(wr_sel);
   assign wr_ok   = wr_en && !sys_rst;
   assign ctrl_wr = wr_ok && (sel == SEL_CTRL);
   assign stat_wr = wr_ok && (sel == SEL_STAT);
   assign tcfg_wr = wr_ok && (sel == SEL_TCFG);
   assign ien_wr  = wr_ok && (sel == SEL_IEN);

   for (genvar i = 0; i < NUM_EVT; i++) begin : g_clr
      localparam int P = evt_stat_pos(i);
      assign evt_clr[i] = stat_wr && wr_data[P];
   end

   tamper_evt_bank #(.SYNC_STAGES(EVT_SYNC)) evt_bank_i (
      .clk(clk), .bat_rst_n(bat_rst_n), .evt_raw(evt_in),
      .clr_req(evt_clr), .evt_now(evt_now), .evt_stat(evt_stat)
   );

   tamper_lock_reg #(.REG_W(REG_W)) lock_reg_i (
      .clk(clk), .bat_rst_n(bat_rst_n), .sys_rst(sys_rst),
      .wr(ctrl_wr), .wdata(wr_data), .ctrl_q(ctrl_q)
   );

   assign evt_hit    = |((evt_stat | evt_now) & tcfg_q);
   assign cfg_locked = (|evt_stat) && (ctrl_q[CTL_CFG_HL] || ctrl_q[CTL_CFG_SL]);

   tamper_sec_flags flags_i (
      .clk(clk), .bat_rst_n(bat_rst_n), .sys_rst(sys_rst),
      .stat_wr(stat_wr), .sv_w1c(wr_data[ST_SV]), .nv_w1c(wr_data[ST_NV]),
      .sv_set(evt_hit), .fail_hl(ctrl_q[CTL_FAIL_HL]),
      .svf_q(svf_q), .nvf_q(nvf_q)
   );

   always_ff @(posedge clk or negedge bat_rst_n) begin
      if (!bat_rst_n)                 tcfg_q <= '0;
      else if (tcfg_wr && !cfg_locked) tcfg_q <= wr_data[NUM_EVT-1:0];
   end

   always_ff @(posedge clk or negedge bat_rst_n) begin
      if (!bat_rst_n)  ien_q <= 1'b0;
      else if (ien_wr) ien_q <= wr_data[0];
   end

   always_comb begin
      status_o = '0;
      for (int i = 0; i < NUM_EVT; i++) status_o[evt_stat_pos(i)] = evt_stat[i];
      status_o[ST_NV] = nvf_q;
      status_o[ST_SV] = svf_q;
   end

   assign ctrl_o    = ctrl_q;
   assign tcfg_o    = REG_W'(tcfg_q);
   assign irq_en_o  = REG_W'(ien_q);
   assign sec_irq_o = svf_q && ien_q;
   assign tc_run_o  = ctrl_q[CTL_TC_EN] && !svf_q && !nvf_q;
endmodule

// File: rtl/tamper_sec_ctrl_chk.sv
module tamper_sec_ctrl_chk
   import tamper_sm_pkg::*;
#(
   parameter int REG_W = 32
) (
   input logic               clk,
   input logic               bat_rst_n,
   input logic [REG_W-1:0]   status,
   input logic [NUM_EVT-1:0] tcfg,
   input logic               cfg_hl,
   input logic               cfg_sl,
   input logic               fail_hl
);
   logic [NUM_EVT-1:0] ev;
   logic               unused_status;

   always_comb begin
      for (int i = 0; i < NUM_EVT; i++) ev[i] = status[evt_stat_pos(i)];
   end
   assign unused_status = ^status;

   // R4
   enabled_evt_fail_chk: assert property (@(posedge clk) disable iff (!bat_rst_n)
      (|(ev & tcfg)) |=> status[ST_SV]);

   // R7
   svf_needs_nv_chk: assert property (@(posedge clk) disable iff (!bat_rst_n)
      (status[ST_SV] && !status[ST_NV]) |=> status[ST_SV]);

   // R6
   svf_fail_hl_chk: assert property (@(posedge clk) disable iff (!bat_rst_n)
      (status[ST_SV] && fail_hl) |=> status[ST_SV]);

   // R8
   nvf_hold_chk: assert property (@(posedge clk) disable iff (!bat_rst_n)
      (status[ST_NV] && status[ST_SV]) |=> status[ST_NV]);

   // R9
   cfg_locked_stable_chk: assert property (@(posedge clk) disable iff (!bat_rst_n)
      ((|ev) && (cfg_hl || cfg_sl)) |=> $stable(tcfg));

   // R10
   cfg_hl_sticky_chk: assert property (@(posedge clk) disable iff (!bat_rst_n)
      cfg_hl |=> cfg_hl);

   // R10
   fail_hl_sticky_chk: assert property (@(posedge clk) disable iff (!bat_rst_n)
      fail_hl |=> fail_hl);
endmodule

bind tamper_sec_ctrl tamper_sec_ctrl_chk #(.REG_W(REG_W)) chk_i (
   .clk(clk), .bat_rst_n(bat_rst_n), .status(status_o),
   .tcfg(tcfg_o[tamper_sm_pkg::NUM_EVT-1:0]),
   .cfg_hl(ctrl_o[tamper_sm_pkg::CTL_CFG_HL]),
   .cfg_sl(ctrl_o[tamper_sm_pkg::CTL_CFG_SL]),
   .fail_hl(ctrl_o[tamper_sm_pkg::CTL_FAIL_HL])
);

// File: tb/tamper_sec_ctrl_tb_top.sv
module tamper_sec_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        bat_rst_n = 1'b0;
   logic        sys_rst = 1'b0;
   logic [9:0]  evt_in = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] ctrl_o, status_o, tcfg_o, irq_en_o;
   logic        sec_irq_o, tc_run_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   tamper_sec_ctrl dut_i (
      .clk(clk), .bat_rst_n(bat_rst_n), .sys_rst(sys_rst), .evt_in(evt_in),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .ctrl_o(ctrl_o), .status_o(status_o), .tcfg_o(tcfg_o), .irq_en_o(irq_en_o),
      .sec_irq_o(sec_irq_o), .tc_run_o(tc_run_o)
   );

   function automatic int spos(input int i);
      if (i == 9) return 3;
      if (i == 8) return 2;
      return 16 + i;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic pulse_sys;
      @(negedge clk); sys_rst = 1'b1;
      @(negedge clk); sys_rst = 1'b0;
   endtask

   task automatic pulse_evt(input int i);
      @(negedge clk); evt_in = 10'(1 << i);
      @(negedge clk); evt_in = '0;
      idle(4);
   endtask

   task automatic bat_reset;
      @(negedge clk); bat_rst_n = 1'b0;
      @(negedge clk);
      check("R1 status", status_o, 32'h2);
      check("R1 ctrl", ctrl_o, 32'h0);
      check("R1 tcfg", tcfg_o, 32'h0);
      check("R1 irq_en", irq_en_o, 32'h0);
      check("R1 outputs", {30'd0, sec_irq_o, tc_run_o}, 32'h0);
      bat_rst_n = 1'b1;
      idle(1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      idle(2);
      bat_reset();

      // leave non-valid into valid, enable counter
      wr(2'd1, 32'h2);
      check("R8 nvf cleared", status_o, 32'h0);
      wr(2'd0, 32'h8);
      check("R5 run in valid", {31'd0, tc_run_o}, 32'h1);

      // sweep every event through failure and recovery
      for (int i = 0; i < 10; i++) begin
         logic [31:0] eb;
         eb = 32'h1 << spos(i);
         pulse_evt(i);
         check($sformatf("R2 latch evt%0d", i), status_o, eb);
         wr(2'd2, 32'h1 << i);
         idle(1);
         check($sformatf("R4 fail evt%0d", i), status_o, eb | 32'h1);
         check($sformatf("R5 stop evt%0d", i), {31'd0, tc_run_o}, 32'h0);
         wr(2'd1, 32'h1);
         check($sformatf("R7 enabled pending evt%0d", i), status_o, eb | 32'h1);
         wr(2'd2, 32'h0);
         check($sformatf("R9 cfg unlocked evt%0d", i), tcfg_o, 32'h0);
         wr(2'd1, eb);
         check($sformatf("R3 clear evt%0d", i), status_o, 32'h1);
         wr(2'd1, 32'h1);
         check($sformatf("R7 no nvf evt%0d", i), status_o, 32'h1);
         pulse_sys();
         check($sformatf("R6 combined evt%0d", i), status_o, 32'h3);
         wr(2'd1, 32'h2);
         check($sformatf("R8 blocked evt%0d", i), status_o, 32'h3);
         wr(2'd1, 32'h1);
         check($sformatf("R7 svf clear evt%0d", i), status_o, 32'h2);
         wr(2'd1, 32'h2);
         check($sformatf("R8 nvf clear evt%0d", i), status_o, 32'h0);
         check($sformatf("R5 resume evt%0d", i), {31'd0, tc_run_o}, 32'h1);
      end

      // R3: held event wins over clear
      @(negedge clk); evt_in = 10'h004;
      idle(4);
      wr(2'd1, 32'h1 << spos(2));
      check("R3 held set wins", status_o, 32'h1 << spos(2));
      evt_in = '0;
      idle(3);
      wr(2'd1, 32'h1 << spos(2));
      check("R3 clear after release", status_o, 32'h0);

      // R9/R10: soft config lock
      wr(2'd0, 32'h2000_0008);
      check("R10 soft lock set", ctrl_o, 32'h2000_0008);
      wr(2'd2, 32'h020);
      check("R9 no pending accepted", tcfg_o, 32'h020);
      pulse_evt(9);
      wr(2'd2, 32'h000);
      check("R9 soft lock rejects", tcfg_o, 32'h020);
      wr(2'd0, 32'h0);
      check("R10 write 0 keeps lock", ctrl_o, 32'h2000_0000);
      pulse_sys();
      check("R10 sys clears soft", ctrl_o, 32'h0);
      wr(2'd2, 32'h000);
      check("R9 accepted after unlock", tcfg_o, 32'h0);
      wr(2'd1, 32'h8);
      check("R3 mono cleared", status_o, 32'h0);

      // R9/R10: hard config lock survives system reset
      wr(2'd0, 32'h4000_0000);
      pulse_evt(8);
      wr(2'd2, 32'h3);
      check("R9 hard lock rejects", tcfg_o, 32'h0);
      pulse_sys();
      check("R10 hard survives sys", ctrl_o, 32'h4000_0000);
      wr(2'd1, 32'h4);
      wr(2'd2, 32'h3);
      check("R9 hard lock no pending", tcfg_o, 32'h3);
      bat_reset();
      check("R10 battery clears hard", ctrl_o, 32'h0);

      // R6/R11: failure hard lock
      wr(2'd1, 32'h2);
      wr(2'd0, 32'h0001_0008);
      wr(2'd3, 32'h1);
      wr(2'd2, 32'h001);
      pulse_evt(0);
      check("R4 voltage fail", status_o, 32'h0001_0001);
      check("R11 irq on", {31'd0, sec_irq_o}, 32'h1);
      wr(2'd2, 32'h0);
      wr(2'd1, 32'h0001_0000);
      pulse_sys();
      check("R6 hl blocks combined", status_o, 32'h1);
      wr(2'd1, 32'h1);
      check("R6 hl blocks svf clear", status_o, 32'h1);
      wr(2'd3, 32'h0);
      check("R11 irq off", {31'd0, sec_irq_o}, 32'h0);
      bat_reset();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule